// File: doc/BRIEF.md
# Prioritized Bus Interrupt Arbiter

The arbiter sits between a set of peripheral interrupt sources and the processor's trap logic. Each source carries a fixed 3-bit bus level and a 16-bit vector, supplied as tie-off inputs, plus a mode bit. The mode bit selects a pulse-style (edge) source or a held (level) source. A source joins the queue of its level when its request line rises. It leaves the queue when the line falls. An edge source also leaves the queue when it is granted.

At every instruction boundary that the processor marks with a strobe, the arbiter looks only at levels strictly above the processor's current priority. That priority is the 3-bit field the processor keeps in bits 7 to 5 of its status word. The arbiter takes the highest populated level and, inside it, the request that has waited longest. It grants one source. One cycle later it presents the grant flag, the vector and a one-cycle acknowledge pulse to the chosen source. If the processor was idling in its wait-for-interrupt state at that boundary, the same registered cycle also raises a wake-up flag. While the processor is halted, no request is examined.

Top module: `intarb_top`

## Requirements
- R1: While reset is held and after it is released, grant_valid, grant_vector, ack and wake are all zero, and no request is pending until a request line rises.
- R2: A source is grantable only if its level is strictly greater than cpu_prio. A level-0 source is never granted, a level-7 source is grantable whenever cpu_prio is below 7, and cpu_prio equal to 7 blocks every grant.
- R3: Among the grantable sources, the one on the highest level is chosen.
- R4: A grant is decided only in a cycle where boundary is high. In the next cycle grant_valid is 1, grant_vector equals the chosen source's vector, and ack has only the chosen source's bit set. In every other cycle grant_valid, grant_vector and ack are zero, so ack is a pulse one cycle long.
- R5: Inside one level, the source whose request rose first is chosen. Sources that rise in the same cycle are ordered by lower index first.
- R6: A request held high keeps its original place in its level's queue across grants. It is never queued a second time behind later arrivals.
- R7: An edge source (edge_mode bit 1) stops pending when it is granted. It is not granted again until its request falls and rises again.
- R8: A level source (edge_mode bit 0) stays pending after a grant for as long as its request stays high.
- R9: A request that falls leaves its queue at once, whether or not it was granted. If it rises again, it joins behind the sources already waiting.
- R10: wake is 1 together with a grant when waiting was high in the boundary cycle. With no grant, wake stays 0.
- R11: When halted is high in a boundary cycle, no grant is made, and pending requests are kept for later boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_SRC | Request line per source |
| edge_mode | input | NUM_SRC | 1 = edge source (cleared on grant), 0 = level source |
| src_level | input | NUM_SRC*3 | Fixed bus level per source, source i in bits 3i+2..3i |
| src_vector | input | NUM_SRC*VEC_W | Fixed vector per source, source i in bits VEC_W*i+VEC_W-1..VEC_W*i |
| cpu_prio | input | 3 | Processor priority field (status word bits 7..5) |
| boundary | input | 1 | Instruction-boundary strobe, one check per high cycle |
| halted | input | 1 | Processor halted, grants suppressed |
| waiting | input | 1 | Processor idling in wait-for-interrupt |
| grant_valid | output | 1 | Registered grant flag |
| grant_vector | output | VEC_W | Vector of the granted source, zero without a grant |
| ack | output | NUM_SRC | One-cycle acknowledge to the granted source |
| wake | output | 1 | Wake-up from the wait state, paired with a grant |

## Verification
On every cycle, the bound properties confirm the following: at most one acknowledge bit is set, a grant only follows a boundary strobe while the processor was not halted, and the granted source's level lies above the priority seen in that boundary cycle. They also confirm that every acknowledged source had its request high, that an edge source is never acknowledged twice in a row, and that wake appears only alongside a grant. The checks against waiting order need concrete histories, so they stay with the bench's scenarios. These cover first-come order inside a level, index tie-breaks, keeping a held request's place, rejoining at the back after a drop, and pending work surviving a halt.

// File: rtl/intarb_pkg.sv
`timescale 1ns/1ps
package intarb_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/intarb_track.sv
`timescale 1ns/1ps
// Per-source pending state and arrival order.
// ahead_o[i*N+j] = 1 means source i queued before source j.
module intarb_track #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic [N-1:0]   edge_mode,
    input  logic           take_fire,
    input  logic [N-1:0]   take_sel,
    output logic [N-1:0]   pend_o,
    output logic [N*N-1:0] ahead_o
);
    typedef struct packed {
        logic [N-1:0]   pend;
        logic [N-1:0]   req_prev;
        logic [N*N-1:0] ahead;
    } trk_t;

    trk_t         s_d, s_q;
    logic [N-1:0] join_w;

    always_comb begin
        s_d          = s_q;
        s_d.req_prev = req;
        join_w       = req & ~s_q.req_prev & ~s_q.pend;
        for (int i = 0; i < N; i++) begin
            if (!req[i])
                s_d.pend[i] = 1'b0;
            else if (join_w[i])
                s_d.pend[i] = 1'b1;
            else if (take_fire && take_sel[i] && edge_mode[i])
                s_d.pend[i] = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (i != j) begin
                    if (join_w[i] && join_w[j])
                        s_d.ahead[i*N+j] = (i < j);
                    else if (join_w[j])
                        s_d.ahead[i*N+j] = 1'b1;
                    else if (join_w[i])
                        s_d.ahead[i*N+j] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o  = s_q.pend;
    assign ahead_o = s_q.ahead;
endmodule

// File: rtl/intarb_pick.sv
`timescale 1ns/1ps
// Combinational selection: highest eligible level, oldest within it.
module intarb_pick
    import intarb_pkg::*;
#(
    parameter int N     = 8,
    parameter int VEC_W = 16
) (
    input  logic [N-1:0]       pend,
    input  logic [N*N-1:0]     ahead,
    input  logic [N*LVL_W-1:0] src_level,
    input  logic [N*VEC_W-1:0] src_vector,
    input  lvl_t               cpu_prio,
    output logic               found,
    output logic [N-1:0]       sel,
    output logic [VEC_W-1:0]   vec
);
    lvl_t               lvl_of [N];
    logic [VEC_W-1:0]   vec_of [N];
    logic [N-1:0]       elig, cand;
    logic [NUM_LVL-1:0] lvl_hit;
    lvl_t               top_lvl;
    logic               beats;

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign lvl_of[g] = src_level[g*LVL_W +: LVL_W];
        assign vec_of[g] = src_vector[g*VEC_W +: VEC_W];
    end

    always_comb begin
        elig    = '0;
        lvl_hit = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (lvl_of[i] > cpu_prio)) begin
                elig[i]             = 1'b1;
                lvl_hit[lvl_of[i]]  = 1'b1;
            end
        end
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++)
            if (lvl_hit[l]) top_lvl = lvl_t'(l);
        for (int i = 0; i < N; i++)
            cand[i] = elig[i] && (lvl_of[i] == top_lvl);
        sel   = '0;
        beats = 1'b0;
        for (int j = 0; j < N; j++) begin
            beats = cand[j];
            for (int i = 0; i < N; i++)
                if (i != j && cand[i] && !ahead[j*N+i]) beats = 1'b0;
            sel[j] = beats;
        end
        found = |cand;
        vec   = '0;
        for (int j = 0; j < N; j++)
            if (sel[j]) vec = vec | vec_of[j];
    end
endmodule

// File: rtl/intarb_top.sv
`timescale 1ns/1ps
module intarb_top
    import intarb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC-1:0]       edge_mode,
    input  logic [NUM_SRC*LVL_W-1:0] src_level,
    input  logic [NUM_SRC*VEC_W-1:0] src_vector,
    input  logic [LVL_W-1:0]         cpu_prio,
    input  logic                     boundary,
    input  logic                     halted,
    input  logic                     waiting,
    output logic                     grant_valid,
    output logic [VEC_W-1:0]         grant_vector,
    output logic [NUM_SRC-1:0]       ack,
    output logic                     wake
);
    typedef struct packed {
        logic               gv;
        logic [VEC_W-1:0]   vec;
        logic [NUM_SRC-1:0] ack;
        logic               wk;
    } out_t;

    out_t                   o_d, o_q;
    logic                   scan_en, found, take_fire;
    logic [NUM_SRC-1:0]     pend, sel;
    logic [NUM_SRC*NUM_SRC-1:0] ahead;
    logic [VEC_W-1:0]       pick_vec;

    assign scan_en   = boundary & ~halted;
    assign take_fire = scan_en & found;

    intarb_track #(.N(NUM_SRC)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .edge_mode (edge_mode),
        .take_fire (take_fire),
        .take_sel  (sel),
        .pend_o    (pend),
        .ahead_o   (ahead)
    );

    intarb_pick #(.N(NUM_SRC), .VEC_W(VEC_W)) u_pick (
        .pend       (pend),
        .ahead      (ahead),
        .src_level  (src_level),
        .src_vector (src_vector),
        .cpu_prio   (cpu_prio),
        .found      (found),
        .sel        (sel),
        .vec        (pick_vec)
    );

    always_comb begin
        o_d = '0;
        if (take_fire) begin
            o_d.gv  = 1'b1;
            o_d.vec = pick_vec;
            o_d.ack = sel;
            o_d.wk  = waiting;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign grant_valid  = o_q.gv;
    assign grant_vector = o_q.vec;
    assign ack          = o_q.ack;
    assign wake         = o_q.wk;
endmodule

// File: rtl/intarb_checker.sv
`timescale 1ns/1ps
module intarb_checker
    import intarb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       req,
    input logic [NUM_SRC-1:0]       edge_mode,
    input logic [NUM_SRC*LVL_W-1:0] src_level,
    input logic [LVL_W-1:0]         cpu_prio,
    input logic                     boundary,
    input logic                     halted,
    input logic                     waiting,
    input logic                     grant_valid,
    input logic [NUM_SRC-1:0]       ack,
    input logic                     wake
);
    lvl_t g_lvl;
    always_comb begin
        g_lvl = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (ack[i]) g_lvl = g_lvl | src_level[i*LVL_W +: LVL_W];
    end

    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
    p_grant_after_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(boundary));
    p_halt_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !$past(halted));
    p_above_threshold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (g_lvl > $past(cpu_prio)));
    p_wake_with_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (grant_valid && $past(waiting)));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        p_acked_was_requested_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ack[g] |-> $past(req[g]));
        p_edge_not_twice_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[g] && $past(edge_mode[g])) |=> !ack[g]);
    end
endmodule

bind intarb_top intarb_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .edge_mode   (edge_mode),
    .src_level   (src_level),
    .cpu_prio    (cpu_prio),
    .boundary    (boundary),
    .halted      (halted),
    .waiting     (waiting),
    .grant_valid (grant_valid),
    .ack         (ack),
    .wake        (wake)
);

// File: tb/intarb_top_bench.sv
`timescale 1ns/1ps
module intarb_top_bench;
    localparam int N  = 8;
    localparam int VW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [N-1:0]  req, edge_mode;
    logic [N*3-1:0]  src_level;
    logic [N*VW-1:0] src_vector;
    logic [2:0]    cpu_prio;
    logic          boundary, halted, waiting;
    logic          grant_valid, wake;
    logic [VW-1:0] grant_vector;
    logic [N-1:0]  ack;

    intarb_top #(.NUM_SRC(N), .VEC_W(VW)) u_intarb_top (
        .clk(clk), .rst_n(rst_n), .req(req), .edge_mode(edge_mode),
        .src_level(src_level), .src_vector(src_vector), .cpu_prio(cpu_prio),
        .boundary(boundary), .halted(halted), .waiting(waiting),
        .grant_valid(grant_valid), .grant_vector(grant_vector), .ack(ack), .wake(wake)
    );

    typedef struct packed {
        logic          v;
        logic [VW-1:0] vec;
        logic [N-1:0]  ack;
        logic          wk;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  e_cur, g_cur;
    string t_cur;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // levels: src0..7 = 4,4,6,7,0,4,5,2 ; edge sources: 0,2,4,7
    localparam logic [2:0] LVL [N] = '{3'd4, 3'd4, 3'd6, 3'd7, 3'd0, 3'd4, 3'd5, 3'd2};

    function automatic logic [VW-1:0] vec_of(int i);
        return 16'h0100 + 16'(i * 8);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step(int who, int prio, bit hlt, bit wt, string tag);
        exp_t e;
        e.v   = (who >= 0);
        e.vec = (who >= 0) ? vec_of(who) : '0;
        e.ack = (who >= 0) ? N'(1 << who) : '0;
        e.wk  = (who >= 0) && wt;
        cpu_prio = 3'(prio);
        halted   = hlt;
        waiting  = wt;
        boundary = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        boundary = 1'b0;
        halted   = 1'b0;
        waiting  = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: pops one expectation per boundary cycle
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            if (boundary) begin
                #2;
                g_cur = {grant_valid, grant_vector, ack, wake};
                if (exp_q.size() == 0) begin
                    chk("R4 grant without expectation", 64'(g_cur), 64'd0);
                end else begin
                    e_cur = exp_q.pop_front();
                    t_cur = tag_q.pop_front();
                    chk(t_cur, 64'(g_cur), 64'(e_cur));
                end
            end else begin
                #2;
                chk("R4 quiet without boundary", 64'({grant_valid, grant_vector, ack, wake}), 64'd0);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; edge_mode = 8'h95;
        cpu_prio = '0; boundary = 0; halted = 0; waiting = 0;
        for (int i = 0; i < N; i++) begin
            src_level[i*3 +: 3]   = LVL[i];
            src_vector[i*VW +: VW] = vec_of(i);
        end
        idle(3);
        chk("R1 outputs in reset", 64'({grant_valid, grant_vector, ack, wake}), 64'd0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 outputs after reset", 64'({grant_valid, grant_vector, ack, wake}), 64'd0);
        step(-1, 0, 0, 0, "R1 queues empty after reset");

        // R3 level order, R7 edge clear and re-edge
        req[0] = 1; req[2] = 1; idle(1);
        step(2, 0, 0, 0, "R3 highest level first");
        step(0, 0, 0, 0, "R7 edge src2 cleared, src0 next");
        step(-1, 0, 0, 0, "R7 held edge requests not regranted");
        req[2] = 0; idle(1); req[2] = 1; idle(1);
        step(2, 0, 0, 0, "R7 new rising edge requeues");
        req[0] = 0; req[2] = 0; idle(1);

        // R2 threshold
        req[6] = 1; idle(1);
        step(-1, 5, 0, 0, "R2 level equal to priority masked");
        step(6, 4, 0, 0, "R2 level above priority granted");
        req[3] = 1; idle(1);
        step(-1, 7, 0, 0, "R2 priority 7 masks all");
        step(3, 6, 0, 0, "R2 level 7 above priority 6");
        req[3] = 0; req[6] = 0; idle(1);
        req[4] = 1; idle(1);
        step(-1, 0, 0, 0, "R2 level 0 never granted");
        req[4] = 0; idle(1);

        // R5 first come, R6/R8 held place
        req[5] = 1; idle(1); req[1] = 1; idle(1);
        step(5, 0, 0, 0, "R5 earlier arrival wins");
        step(5, 0, 0, 0, "R6 R8 held level source keeps front");
        req[5] = 0; idle(1);
        step(1, 0, 0, 0, "R9 dropped source leaves queue");
        req[1] = 0; idle(1);

        // R9 removal of never-granted, rejoin at back
        req[0] = 1; idle(1); req[1] = 1; idle(1);
        req[0] = 0; idle(1); req[0] = 1; idle(1);
        step(1, 0, 0, 0, "R9 rejoined source goes behind");
        step(1, 0, 0, 0, "R8 level source still pending");
        req[1] = 0; idle(1);
        step(0, 0, 0, 0, "R9 rejoined source still pending");
        req[0] = 0; idle(1);

        // R5 same-cycle tie
        req[1] = 1; req[5] = 1; idle(1);
        step(1, 0, 0, 0, "R5 same-cycle tie lower index");
        req[1] = 0; req[5] = 0; idle(1);

        // R11 halt, R10 wake
        req[6] = 1; idle(1);
        step(-1, 0, 1, 0, "R11 halted blocks grant");
        step(6, 0, 0, 0, "R11 request kept across halt");
        step(6, 0, 0, 1, "R10 wake with grant");
        req[6] = 0; idle(1);
        step(-1, 0, 0, 1, "R10 no wake without grant");

        idle(3);
        chk("R4 all expectations consumed", 64'(exp_q.size()), 64'd0);
        done = 1;
        summary();
        $finish;
    end
endmodule